// File: doc/BRIEF.md
# Multi-Channel Temperature Monitor Sequencer

This block scans three thermistor inputs, one at a time, through an off-chip analog multiplexer and an off-chip serial ADC. It drives the multiplexer select lines. After each select change it waits a programmable number of clock cycles so the analog path can settle. It then runs one serial ADC frame: chip-select goes low, twelve clock pulses shift the sample in MSB first, and chip-select goes high again. The newest 12-bit sample of each channel is kept in its own status register.

Each channel has its own programmable limit. When a new sample is strictly above the limit, a sticky alarm flag for that channel is set. Software clears a flag by writing a one to that channel's clear bit. Software reaches everything through a small memory-mapped register file with eight word addresses. Four of them are control registers (scan configuration and three limits). The other four are status registers (three readings and the alarm flags). A global enable starts and stops the scan. While it is clear, the ADC stays deselected.

Top module: `tmon_seq`

## Requirements
- R1: After reset, adc_cs_n is 1, adc_sclk is 0 and mux_sel is 0. Reads return 0x0000 at address 0, 0x0FFF at addresses 1 to 3, and 0x0000 at addresses 4 to 7.
- R2: Address 0 holds the scan enable in bit 0 and the settle count in bits 15:8; its bits 3:1 always read as 0. Addresses 1, 2 and 3 hold the 12-bit limits of channels 0, 1 and 2 in bits 11:0. A write to any of these addresses reads back with all unused bits as 0.
- R3: While the scan enable is 0, adc_cs_n stays 1, adc_sclk stays 0, mux_sel is 0 and no reading changes. All three hold from the second clock edge after the enable is cleared.
- R4: With the scan enabled, conversions visit channels in the order 0, 1, 2, 0, … . A scan always starts at channel 0, both after reset and after re-enable.
- R5: After each change of mux_sel, adc_cs_n falls exactly settle count + 1 clock cycles later. mux_sel does not change while adc_cs_n is 0.
- R6: A conversion frame has the following shape:
  - adc_cs_n is low for exactly 24 × SCLK_HALF cycles.
  - adc_sclk toggles every SCLK_HALF cycles and gives exactly 12 rising edges.
  - adc_sdo is sampled at each rising edge, MSB first.
  - adc_sclk is 0 whenever adc_cs_n is 1.
- R7: When a frame completes, the 12-bit word read from the ADC appears in bits 11:0 of status address 4 + channel, with bits 15:12 reading as 0.
- R8: A completed sample strictly greater than its channel's limit sets that channel's alarm flag. A sample equal to or below the limit does not set it.
- R9: Alarm flags are sticky. A flag is cleared only by a write to address 0 with bit 1 + channel set. A later sample below the limit leaves it set, and so does a clear bit written for another channel.
- R10: Status address 7 reports the alarm flags of channels 0, 1 and 2 in bits 2:0, and the rest of the word reads as 0.
- R11: Clearing the enable during a frame aborts the frame. The aborted channel's reading is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| mux_sel | output | 2 | Analog multiplexer channel select |
| adc_cs_n | output | 1 | ADC chip-select, active low; its falling edge starts a conversion |
| adc_sclk | output | 1 | ADC serial clock |
| adc_sdo | input | 1 | ADC serial data, MSB first |

## Verification
The alarm assertion checks a newly set flag against a limit that did not change in the same cycle. So it assumes software does not rewrite a limit on the exact edge a frame completes. The bench meets this by writing limits only while it waits through whole frames. The serial capture assumes the ADC changes adc_sdo only after a falling edge of adc_sclk, or when chip-select falls. The bench's ADC model updates its bit on the clock half-cycle after such an edge, so each bit stays stable across the rising edge that samples it. Settle-count writes happen only with the scan running between frames or while disabled. This keeps the measured select-to-select gap a clean function of one settle value.

// File: rtl/tmon_seq.sv
module tmon_seq #(
  parameter int NCH       = 3,
  parameter int ADC_W     = 12,
  parameter int BUS_W     = 16,
  parameter int SET_W     = 8,
  parameter int SCLK_HALF = 2,
  localparam int SEL_W    = $clog2(NCH),
  localparam int AW       = $clog2(2 * NCH + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  output logic [SEL_W-1:0] mux_sel,
  output logic             adc_cs_n,
  output logic             adc_sclk,
  input  logic             adc_sdo
);

  localparam int LIM_BASE = 1;
  localparam int RD_BASE  = NCH + 1;
  localparam int ALM_ADDR = 2 * NCH + 1;
  localparam int HC_W     = $clog2(SCLK_HALF) + 1;
  localparam int BC_W     = $clog2(ADC_W + 1);

  typedef enum logic [1:0] {S_IDLE, S_SETTLE, S_SHIFT, S_DONE} st_t;

  st_t              st;
  logic             scan_en;
  logic [SET_W-1:0] settle;
  logic [SET_W-1:0] wait_cnt;
  logic [HC_W-1:0]  hcnt;
  logic [BC_W-1:0]  nbit;
  logic             sclk_q;
  logic [ADC_W-1:0] sreg;
  logic [SEL_W-1:0] ch;
  logic [ADC_W-1:0] lim [NCH];
  logic [ADC_W-1:0] rd  [NCH];
  logic [NCH-1:0]   alm;

  wire             cfg_wr = bus_wr && bus_addr == AW'(0);
  wire [NCH-1:0]   clr    = cfg_wr ? bus_wdata[NCH:1] : '0;
  wire             done   = st == S_DONE;

  assign mux_sel  = ch;
  assign adc_cs_n = st != S_SHIFT;
  assign adc_sclk = sclk_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scan_en <= 1'b0;
      settle  <= '0;
    end else if (cfg_wr) begin
      scan_en <= bus_wdata[0];
      settle  <= bus_wdata[8 +: SET_W];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st       <= S_IDLE;
      ch       <= '0;
      wait_cnt <= '0;
      hcnt     <= '0;
      nbit     <= '0;
      sclk_q   <= 1'b0;
      sreg     <= '0;
    end else if (!scan_en) begin
      st       <= S_IDLE;
      ch       <= '0;
      wait_cnt <= '0;
      hcnt     <= '0;
      nbit     <= '0;
      sclk_q   <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          st       <= S_SETTLE;
          wait_cnt <= '0;
        end
        S_SETTLE:
          if (wait_cnt >= settle) begin
            st   <= S_SHIFT;
            hcnt <= '0;
            nbit <= '0;
          end else begin
            wait_cnt <= wait_cnt + 1'b1;
          end
        S_SHIFT:
          if (hcnt == HC_W'(SCLK_HALF - 1)) begin
            hcnt   <= '0;
            sclk_q <= ~sclk_q;
            if (!sclk_q) begin
              sreg <= {sreg[ADC_W-2:0], adc_sdo};
              nbit <= nbit + 1'b1;
            end else if (nbit == BC_W'(ADC_W)) begin
              st <= S_DONE;
            end
          end else begin
            hcnt <= hcnt + 1'b1;
          end
        default: begin
          ch       <= (ch == SEL_W'(NCH - 1)) ? '0 : ch + 1'b1;
          st       <= S_SETTLE;
          wait_cnt <= '0;
        end
      endcase
    end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    wire here = done && ch == SEL_W'(i);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) lim[i] <= '1;
      else if (bus_wr && bus_addr == AW'(LIM_BASE + i)) lim[i] <= bus_wdata[ADC_W-1:0];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) rd[i] <= '0;
      else if (here) rd[i] <= sreg;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) alm[i] <= 1'b0;
      else if (here && sreg > lim[i]) alm[i] <= 1'b1;
      else if (clr[i]) alm[i] <= 1'b0;

    a_r9_alarm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      alm[i] && !clr[i] |=> alm[i]);

    a_r8_alarm_above_limit: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alm[i]) && $stable(lim[i]) |-> rd[i] > lim[i]);
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AW'(0)) begin
      bus_rdata[0]           = scan_en;
      bus_rdata[8 +: SET_W]  = settle;
    end
    if (bus_addr == AW'(ALM_ADDR)) bus_rdata[NCH-1:0] = alm;
    for (int i = 0; i < NCH; i++) begin
      if (bus_addr == AW'(LIM_BASE + i)) bus_rdata[ADC_W-1:0] = lim[i];
      if (bus_addr == AW'(RD_BASE + i))  bus_rdata[ADC_W-1:0] = rd[i];
    end
  end

  a_r3_idle_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |=> adc_cs_n && !adc_sclk && mux_sel == '0);

  a_r4_select_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(mux_sel) < NCH);

  a_r5_mux_hold_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_cs_n && scan_en |=> $stable(mux_sel));

  a_r6_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    adc_cs_n |-> !adc_sclk);

endmodule

// File: tb/tmon_seq_test.sv
module tmon_seq_test;
  localparam int HALF = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [1:0]  mux_sel;
  logic        adc_cs_n, adc_sclk, adc_sdo;

  tmon_seq #(.SCLK_HALF(HALF)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mux_sel(mux_sel),
    .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk), .adc_sdo(adc_sdo)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0;

  logic [11:0] adc_val [3];
  logic [11:0] sh = '0;
  int pos = 11;
  logic cs_prev = 1'b1, sclk_prev = 1'b0;
  logic [1:0] mux_prev = '0;
  int lowcyc = 0, nrise = 0, frame_err = 0, nframes = 0, gap = 0, last_gap = -1;
  int log_n = 0;
  int log_ch [32];

  assign adc_sdo = sh[pos];

  always @(negedge clk) begin
    if (mux_sel != mux_prev) gap = 0; else gap++;
    if (cs_prev && !adc_cs_n) begin
      sh = adc_val[mux_sel]; pos = 11; lowcyc = 1; nrise = 0;
      last_gap = gap;
      log_ch[log_n % 32] = int'(mux_sel); log_n++;
    end else if (!adc_cs_n) begin
      lowcyc++;
      if (!sclk_prev && adc_sclk) nrise++;
      if (sclk_prev && !adc_sclk && pos > 0) pos--;
    end
    if (!cs_prev && adc_cs_n) begin
      if (nrise != 12 || lowcyc != 24 * HALF) frame_err++;
      nframes++;
    end
    cs_prev = adc_cs_n; sclk_prev = adc_sclk; mux_prev = mux_sel;
  end

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 3'(a); bus_wdata = 16'(d);
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rdreg(int a, output int d);
    @(negedge clk); bus_addr = 3'(a); #1 d = int'(bus_rdata);
  endtask

  task automatic wait_frames(int n);
    int target = nframes + n;
    while (nframes < target) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset;
    int d;
    chk("R1", "cs_n", adc_cs_n, 1);
    chk("R1", "sclk", adc_sclk, 0);
    chk("R1", "mux_sel", mux_sel, 0);
    rdreg(0, d); chk("R1", "cfg", d, 0);
    for (int a = 1; a <= 3; a++) begin rdreg(a, d); chk("R1", "limit", d, 12'hFFF); end
    for (int a = 4; a <= 7; a++) begin rdreg(a, d); chk("R1", "status", d, 0); end
  endtask

  task automatic t_regs;
    int d, f0, l0;
    wr(0, 16'h050E); rdreg(0, d); chk("R2", "cfg readback", d, 16'h0500);
    wr(2, 16'hF123); rdreg(2, d); chk("R2", "limit1 readback", d, 16'h0123);
    wr(2, 16'h0FFF); rdreg(2, d); chk("R2", "limit1 restore", d, 16'h0FFF);
    f0 = nframes; l0 = log_n;
    repeat (60) begin
      @(negedge clk);
      if (!adc_cs_n || adc_sclk) break;
    end
    chk("R3", "cs_n while disabled", adc_cs_n, 1);
    chk("R3", "sclk while disabled", adc_sclk, 0);
    chk("R3", "frames while disabled", nframes - f0 + log_n - l0, 0);
  endtask

  task automatic t_scan;
    int d, l0, e0;
    adc_val[0] = 12'h0A5; adc_val[1] = 12'h5A3; adc_val[2] = 12'hFFE;
    e0 = frame_err; l0 = log_n;
    wr(0, 16'h0301);
    wait_frames(6);
    for (int k = 0; k < 6; k++) chk("R4", "channel order", log_ch[(l0 + k) % 32], k % 3);
    chk("R6", "frame shape errors", frame_err - e0, 0);
    rdreg(4, d); chk("R7", "reading ch0", d, 16'h00A5);
    rdreg(5, d); chk("R7", "reading ch1", d, 16'h05A3);
    rdreg(6, d); chk("R7", "reading ch2", d, 16'h0FFE);
    rdreg(7, d); chk("R10", "no alarms", d, 0);
  endtask

  task automatic t_settle;
    wait_frames(2); chk("R5", "gap settle=3", last_gap, 4);
    wr(0, 16'h0001); wait_frames(3); chk("R5", "gap settle=0", last_gap, 1);
    wr(0, 16'h0901); wait_frames(3); chk("R5", "gap settle=9", last_gap, 10);
    wr(0, 16'h0301); wait_frames(1);
  endtask

  task automatic t_alarm;
    int d;
    wr(1, 16'h00A5); wr(2, 16'h05A2);
    wait_frames(4);
    rdreg(7, d); chk("R8", "strict compare ch1 set ch0 equal clear", d, 3'b010);
    adc_val[1] = 12'h100;
    wait_frames(4);
    rdreg(5, d); chk("R7", "new reading ch1", d, 16'h0100);
    rdreg(7, d); chk("R9", "flag kept after low sample", d, 3'b010);
    wr(0, 16'h0303); rdreg(7, d); chk("R9", "other channel clear", d, 3'b010);
    rdreg(0, d); chk("R2", "clear bits read 0", d, 16'h0301);
    wr(0, 16'h0305); rdreg(7, d); chk("R9", "own clear", d, 0);
    wait_frames(4);
    rdreg(7, d); chk("R10", "stays clear", d, 0);
  endtask

  task automatic t_disable;
    int d, c, old, l0;
    int nv [3];
    nv[0] = 12'h321; nv[1] = 12'h654; nv[2] = 12'h987;
    for (int k = 0; k < 3; k++) adc_val[k] = 12'(nv[k]);
    @(negedge clk);
    while (adc_cs_n) @(negedge clk);
    c = int'(mux_sel);
    rdreg(4 + c, old);
    wr(0, 16'h0300);
    @(negedge clk);
    chk("R3", "cs_n after disable", adc_cs_n, 1);
    chk("R3", "sclk after disable", adc_sclk, 0);
    chk("R3", "mux after disable", mux_sel, 0);
    repeat (40) @(negedge clk);
    rdreg(4 + c, d); chk("R11", "aborted reading kept", d, old);
    l0 = log_n;
    wr(0, 16'h0301);
    wait_frames(3);
    for (int k = 0; k < 3; k++) chk("R4", "restart order", log_ch[(l0 + k) % 32], k);
    for (int k = 0; k < 3; k++) begin rdreg(4 + k, d); chk("R11", "post-restart reading", d, nv[k]); end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    adc_val[0] = '0; adc_val[1] = '0; adc_val[2] = '0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_regs;
    t_scan;
    t_settle;
    t_alarm;
    t_disable;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule